// File: doc/BRIEF.md
# Deep Sleep Wake and Retention Controller

This block runs the always-on side of a deep sleep state in a small controller-style system. A software request puts it to sleep. At that moment it empties the wake-source record and freezes the I/O pad configuration and drive levels. It also captures the external interrupt settings and sends a one-cycle flush to the interrupt controller, so that any interrupt still pending is dropped.

While asleep it watches five wake sources, all arriving as pulses or levels from logic outside the block:

- a power-on event;
- a sleep watchdog timeout;
- a real-time clock alarm, which counts only when the clock is enabled;
- a low level on the external reset pin;
- an edge on the external interrupt pin into its programmed wake level.

The first wake records every source active in that cycle. It sets a sticky woke flag and holds a system reset request for a fixed number of cycles. Wake events and software actions that arrive during that reset window are ignored.

Two general-purpose retention registers, the wake-source record and the status flags keep their contents through sleep and the reset window. The pads stay frozen after wake until software issues an explicit release. A brown-out seen during sleep is kept in a sticky flag that software reads after wake.

Top module: `dslp_ctrl`

## Requirements
- R1: After rstN is low, the block is awake: asleep=0, sysResetReq=0, irqFlush=0, wakeSrc=0, wokeFlag=0, brownOutFlag=0, padsFrozen=0, and both retention registers are 0.
- R2: When sleepReq is high at a clock edge while awake, asleep and padsFrozen are 1 from that edge on. At the same edge wakeSrc clears to 0, and irqFlush is high for exactly that one following cycle.
- R3: While asleep, a wake source active at an edge ends sleep at that edge: asleep falls, sysResetReq rises, and wakeSrc holds the active sources. The wakeSrc bits are: bit0 power-on event, bit1 watchdog timeout, bit2 clock alarm, bit3 external reset (extRstN low), bit4 interrupt pin.
- R4: While asleep, rtcAlarm with rtcEnable=0 does not end sleep.
- R5: The interrupt pin passes through a two-flop synchronizer. It ends sleep only on a change into the wake level (1 if intPolarity was 1 at entry, otherwise 0) while asleep, and only if intEnable was 1 at entry. A level already present at entry does not wake, and the pin wakes three edges after it changes.
- R6: sysResetReq stays high for exactly RST_CYCLES cycles, then the block is awake. Wake events during that window do not change wakeSrc.
- R7: Exit from sleep sets wokeFlag. wokeFlag stays set until a clrWokeFlag pulse while awake.
- R8: A brownOut pulse while asleep sets brownOutFlag. The flag stays set until clrBrownOut while awake. brownOut while awake is ignored.
- R9: gprWe writes gprWdata into retention register gprSel (0 selects gprRd0, 1 selects gprRd1) only while awake. Contents are kept through sleep and the reset window.
- R10: When not frozen, padOeOut=padOe and padDrive=padOe&padOut. When frozen, both show the values captured at entry, so a pad that was an input has padOeOut=0. The freeze lasts past wake until padRelease while awake; padRelease while asleep is ignored.
- R11: sleepReq during the reset window is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Active-low reset of the always-on domain |
| sleepReq | input | 1 | Software request to enter sleep |
| porEvent | input | 1 | Power-on event pulse (wake source) |
| wdtTimeout | input | 1 | Sleep watchdog timeout pulse (wake source) |
| rtcEnable | input | 1 | Real-time clock enabled |
| rtcAlarm | input | 1 | Clock alarm pulse (wake source) |
| extRstN | input | 1 | External reset pin, synchronous, low wakes |
| intPin | input | 1 | Asynchronous external interrupt pin |
| intEnable | input | 1 | Interrupt pin wake enable, captured at entry |
| intPolarity | input | 1 | Interrupt wake level, captured at entry |
| brownOut | input | 1 | Supply brown-out pulse |
| clrWokeFlag | input | 1 | Clear wokeFlag |
| clrBrownOut | input | 1 | Clear brownOutFlag |
| padRelease | input | 1 | Release the pad freeze |
| gprWe | input | 1 | Retention register write enable |
| gprSel | input | 1 | Retention register select |
| gprWdata | input | GPR_W | Retention register write data |
| padOe | input | PAD_N | Live pad output enables (1 = output) |
| padOut | input | PAD_N | Live pad output latch values |
| asleep | output | 1 | Deep sleep active |
| sysResetReq | output | 1 | Reset request to the rest of the system |
| irqFlush | output | 1 | One-cycle pulse that discards pending interrupts |
| wakeSrc | output | 5 | Sources of the most recent wake |
| wokeFlag | output | 1 | Sticky: woke from deep sleep |
| brownOutFlag | output | 1 | Sticky: brown-out seen while asleep |
| padsFrozen | output | 1 | Pad state frozen |
| padOeOut | output | PAD_N | Pad output enables to the pads |
| padDrive | output | PAD_N | Pad drive values to the pads |
| gprRd0 | output | GPR_W | Retention register 0 |
| gprRd1 | output | GPR_W | Retention register 1 |

## Verification
The bench holds the interrupt pin at its wake level across entry. A design that detected levels instead of edges would wake at once, and one that skipped the synchronizer would wake an edge early. It fires a clock alarm and a sleep request inside the reset window; a design without the window mask would overwrite the wake record or fall back asleep. It tries releases and retention writes while asleep and counts the reset-window length, so early unfreezing, lost retention contents and an off-by-one window all show up at the ports.

// File: rtl/dslp_pkg.sv
`timescale 1ns/1ps
package dslp_pkg;
  localparam int WAKE_NUM  = 5;
  localparam int SRC_POR   = 0;
  localparam int SRC_WDT   = 1;
  localparam int SRC_RTC   = 2;
  localparam int SRC_EXT   = 3;
  localparam int SRC_INT   = 4;

  typedef enum logic [1:0] {
    ST_AWAKE  = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_RSTWIN = 2'd2
  } dslpState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic enter;     // entering sleep this cycle
    logic wake;      // leaving sleep this cycle
    logic sleeping;  // in sleep state
    logic awake;     // in normal run state
  } ctrlStrobes_t;
endpackage

// File: rtl/dslp_control.sv
`timescale 1ns/1ps
module dslp_control
  import dslp_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sleepReq,
  input  logic         wakeAny,
  output ctrlStrobes_t strobes,
  output logic         asleep,
  output logic         sysResetReq
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  dslpState_t state;
  logic [CNT_W-1:0] winCnt;

  always_comb begin
    strobes.awake    = (state == ST_AWAKE);
    strobes.sleeping = (state == ST_SLEEP);
    strobes.enter    = strobes.awake && sleepReq;
    strobes.wake     = strobes.sleeping && wakeAny;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_AWAKE;
      winCnt <= '0;
    end else begin
      case (state)
        ST_AWAKE: if (sleepReq) state <= ST_SLEEP;
        ST_SLEEP: if (wakeAny) begin
          state  <= ST_RSTWIN;
          winCnt <= '0;
        end
        ST_RSTWIN: begin
          if (winCnt == CNT_W'(RST_CYCLES - 1)) state <= ST_AWAKE;
          else winCnt <= winCnt + 1'b1;
        end
        default: state <= ST_AWAKE;
      endcase
    end
  end

  assign asleep      = (state == ST_SLEEP);
  assign sysResetReq = (state == ST_RSTWIN);
endmodule

// File: rtl/dslp_datapath.sv
`timescale 1ns/1ps
module dslp_datapath
  import dslp_pkg::*;
#(
  parameter int GPR_W = 16,
  parameter int PAD_N = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic                porEvent,
  input  logic                wdtTimeout,
  input  logic                rtcEnable,
  input  logic                rtcAlarm,
  input  logic                extRstN,
  input  logic                intPin,
  input  logic                intEnable,
  input  logic                intPolarity,
  input  logic                brownOut,
  input  logic                clrWokeFlag,
  input  logic                clrBrownOut,
  input  logic                padRelease,
  input  logic                gprWe,
  input  logic                gprSel,
  input  logic [GPR_W-1:0]    gprWdata,
  input  logic [PAD_N-1:0]    padOe,
  input  logic [PAD_N-1:0]    padOut,
  output logic                wakeAny,
  output logic                irqFlush,
  output logic [WAKE_NUM-1:0] wakeSrc,
  output logic                wokeFlag,
  output logic                brownOutFlag,
  output logic                padsFrozen,
  output logic [PAD_N-1:0]    padOeOut,
  output logic [PAD_N-1:0]    padDrive,
  output logic [GPR_W-1:0]    gprRd0,
  output logic [GPR_W-1:0]    gprRd1
);
  logic intSync1, intSync2, intPrev;
  logic intEnCap, intPolCap;
  logic intEdge;
  logic [WAKE_NUM-1:0] srcNow;
  logic [PAD_N-1:0] oeCap, latCap;

  // two-flop synchronizer plus history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intSync1 <= 1'b0;
      intSync2 <= 1'b0;
      intPrev  <= 1'b0;
    end else begin
      intSync1 <= intPin;
      intSync2 <= intSync1;
      intPrev  <= intSync2;
    end
  end

  assign intEdge = (intSync2 == intPolCap) && (intPrev != intPolCap);

  always_comb begin
    srcNow          = '0;
    srcNow[SRC_POR] = porEvent;
    srcNow[SRC_WDT] = wdtTimeout;
    srcNow[SRC_RTC] = rtcAlarm && rtcEnable;
    srcNow[SRC_EXT] = !extRstN;
    srcNow[SRC_INT] = intEnCap && intEdge;
  end
  assign wakeAny = |srcNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEnCap     <= 1'b0;
      intPolCap    <= 1'b0;
      irqFlush     <= 1'b0;
      wakeSrc      <= '0;
      wokeFlag     <= 1'b0;
      brownOutFlag <= 1'b0;
      padsFrozen   <= 1'b0;
      oeCap        <= '0;
      latCap       <= '0;
    end else begin
      irqFlush <= strobes.enter;
      if (strobes.enter) begin
        intEnCap   <= intEnable;
        intPolCap  <= intPolarity;
        wakeSrc    <= '0;
        padsFrozen <= 1'b1;
        oeCap      <= padOe;
        latCap     <= padOut;
      end
      if (strobes.wake) begin
        wakeSrc  <= srcNow;
        wokeFlag <= 1'b1;
      end
      if (strobes.awake && clrWokeFlag) wokeFlag <= 1'b0;
      if (strobes.sleeping && brownOut) brownOutFlag <= 1'b1;
      if (strobes.awake && clrBrownOut) brownOutFlag <= 1'b0;
      if (strobes.awake && padRelease && !strobes.enter) padsFrozen <= 1'b0;
    end
  end

  // retention registers: writable only in the run state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gprRd0 <= '0;
      gprRd1 <= '0;
    end else if (strobes.awake && gprWe) begin
      if (gprSel) gprRd1 <= gprWdata;
      else        gprRd0 <= gprWdata;
    end
  end

  assign padOeOut = padsFrozen ? oeCap : padOe;
  assign padDrive = padsFrozen ? (oeCap & latCap) : (padOe & padOut);
endmodule

// File: rtl/dslp_ctrl.sv
`timescale 1ns/1ps
module dslp_ctrl
  import dslp_pkg::*;
#(
  parameter int GPR_W      = 16,
  parameter int PAD_N      = 8,
  parameter int RST_CYCLES = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sleepReq,
  input  logic                porEvent,
  input  logic                wdtTimeout,
  input  logic                rtcEnable,
  input  logic                rtcAlarm,
  input  logic                extRstN,
  input  logic                intPin,
  input  logic                intEnable,
  input  logic                intPolarity,
  input  logic                brownOut,
  input  logic                clrWokeFlag,
  input  logic                clrBrownOut,
  input  logic                padRelease,
  input  logic                gprWe,
  input  logic                gprSel,
  input  logic [GPR_W-1:0]    gprWdata,
  input  logic [PAD_N-1:0]    padOe,
  input  logic [PAD_N-1:0]    padOut,
  output logic                asleep,
  output logic                sysResetReq,
  output logic                irqFlush,
  output logic [WAKE_NUM-1:0] wakeSrc,
  output logic                wokeFlag,
  output logic                brownOutFlag,
  output logic                padsFrozen,
  output logic [PAD_N-1:0]    padOeOut,
  output logic [PAD_N-1:0]    padDrive,
  output logic [GPR_W-1:0]    gprRd0,
  output logic [GPR_W-1:0]    gprRd1
);
  ctrlStrobes_t strobes;
  logic wakeAny;

  dslp_control #(.RST_CYCLES(RST_CYCLES)) i_control (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .wakeAny(wakeAny),
    .strobes(strobes), .asleep(asleep), .sysResetReq(sysResetReq)
  );

  dslp_datapath #(.GPR_W(GPR_W), .PAD_N(PAD_N)) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .porEvent(porEvent), .wdtTimeout(wdtTimeout), .rtcEnable(rtcEnable),
    .rtcAlarm(rtcAlarm), .extRstN(extRstN), .intPin(intPin),
    .intEnable(intEnable), .intPolarity(intPolarity), .brownOut(brownOut),
    .clrWokeFlag(clrWokeFlag), .clrBrownOut(clrBrownOut),
    .padRelease(padRelease), .gprWe(gprWe), .gprSel(gprSel),
    .gprWdata(gprWdata), .padOe(padOe), .padOut(padOut),
    .wakeAny(wakeAny), .irqFlush(irqFlush), .wakeSrc(wakeSrc),
    .wokeFlag(wokeFlag), .brownOutFlag(brownOutFlag),
    .padsFrozen(padsFrozen), .padOeOut(padOeOut), .padDrive(padDrive),
    .gprRd0(gprRd0), .gprRd1(gprRd1)
  );
endmodule

// File: rtl/dslp_ctrl_chk.sv
`timescale 1ns/1ps
module dslp_ctrl_chk #(
  parameter int GPR_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             asleep,
  input logic             sysResetReq,
  input logic             irqFlush,
  input logic [4:0]       wakeSrc,
  input logic             wokeFlag,
  input logic             padsFrozen,
  input logic [GPR_W-1:0] gprRd0,
  input logic [GPR_W-1:0] gprRd1
);
  // R6
  rst_not_asleep_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |-> !asleep);

  // R2
  flush_in_sleep_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqFlush |-> asleep);

  // R2
  flush_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqFlush |=> !irqFlush);

  // R3
  wake_recorded_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysResetReq) |-> (wakeSrc != 5'd0));

  // R7
  woke_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysResetReq) |-> wokeFlag);

  // R10
  frozen_asleep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (asleep || sysResetReq) |-> padsFrozen);

  // R9
  gpr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    asleep |=> ($stable(gprRd0) && $stable(gprRd1)));
endmodule

bind dslp_ctrl dslp_ctrl_chk #(.GPR_W(GPR_W)) i_chk (
  .clk(clk), .rstN(rstN), .asleep(asleep), .sysResetReq(sysResetReq),
  .irqFlush(irqFlush), .wakeSrc(wakeSrc), .wokeFlag(wokeFlag),
  .padsFrozen(padsFrozen), .gprRd0(gprRd0), .gprRd1(gprRd1)
);

// File: tb/test_dslp_ctrl.sv
`timescale 1ns/1ps
module test_dslp_ctrl;
  localparam int GPR_W = 16;
  localparam int PAD_N = 4;
  localparam int RST   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepReq = 0, porEvent = 0, wdtTimeout = 0, rtcEnable = 0, rtcAlarm = 0;
  logic extRstN = 1, intPin = 0, intEnable = 0, intPolarity = 0, brownOut = 0;
  logic clrWokeFlag = 0, clrBrownOut = 0, padRelease = 0, gprWe = 0, gprSel = 0;
  logic [GPR_W-1:0] gprWdata = '0;
  logic [PAD_N-1:0] padOe = '0, padOut = '0;
  logic asleep, sysResetReq, irqFlush, wokeFlag, brownOutFlag, padsFrozen;
  logic [4:0] wakeSrc;
  logic [PAD_N-1:0] padOeOut, padDrive;
  logic [GPR_W-1:0] gprRd0, gprRd1;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dslp_ctrl #(.GPR_W(GPR_W), .PAD_N(PAD_N), .RST_CYCLES(RST)) i_dslp_ctrl (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .porEvent(porEvent),
    .wdtTimeout(wdtTimeout), .rtcEnable(rtcEnable), .rtcAlarm(rtcAlarm),
    .extRstN(extRstN), .intPin(intPin), .intEnable(intEnable),
    .intPolarity(intPolarity), .brownOut(brownOut), .clrWokeFlag(clrWokeFlag),
    .clrBrownOut(clrBrownOut), .padRelease(padRelease), .gprWe(gprWe),
    .gprSel(gprSel), .gprWdata(gprWdata), .padOe(padOe), .padOut(padOut),
    .asleep(asleep), .sysResetReq(sysResetReq), .irqFlush(irqFlush),
    .wakeSrc(wakeSrc), .wokeFlag(wokeFlag), .brownOutFlag(brownOutFlag),
    .padsFrozen(padsFrozen), .padOeOut(padOeOut), .padDrive(padDrive),
    .gprRd0(gprRd0), .gprRd1(gprRd1)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enterSleep();
    sleepReq = 1; step(1); sleepReq = 0;
  endtask

  task automatic t_reset();
    chk("R1", "asleep", asleep, 0);
    chk("R1", "sysResetReq", sysResetReq, 0);
    chk("R1", "irqFlush", irqFlush, 0);
    chk("R1", "wakeSrc", wakeSrc, 0);
    chk("R1", "flags", {wokeFlag, brownOutFlag, padsFrozen}, 0);
    chk("R1", "gpr", {gprRd0, gprRd1}, 0);
  endtask

  task automatic t_wdt_window();
    enterSleep();
    chk("R2", "asleep", asleep, 1);
    chk("R2", "irqFlush first", irqFlush, 1);
    chk("R2", "wakeSrc cleared", wakeSrc, 0);
    step(1);
    chk("R2", "irqFlush second", irqFlush, 0);
    step(3);
    chk("R3", "still asleep", asleep, 1);
    wdtTimeout = 1; step(1); wdtTimeout = 0;
    chk("R3", "wdt wake asleep", asleep, 0);
    chk("R3", "wdt reset req", sysResetReq, 1);
    chk("R3", "wdt wakeSrc", wakeSrc, 5'b00010);
    chk("R7", "wokeFlag set", wokeFlag, 1);
    rtcEnable = 1; rtcAlarm = 1; step(1); rtcAlarm = 0; rtcEnable = 0;
    step(2);
    chk("R6", "req last cycle", sysResetReq, 1);
    step(1);
    chk("R6", "req dropped", sysResetReq, 0);
    chk("R6", "window event masked", wakeSrc, 5'b00010);
    chk("R7", "wokeFlag sticky", wokeFlag, 1);
    clrWokeFlag = 1; step(1); clrWokeFlag = 0;
    chk("R7", "wokeFlag cleared", wokeFlag, 0);
    padRelease = 1; step(1); padRelease = 0;
  endtask

  task automatic t_rtc();
    rtcEnable = 0;
    enterSleep();
    rtcAlarm = 1; step(1); rtcAlarm = 0; step(1);
    chk("R4", "alarm disabled no wake", asleep, 1);
    rtcEnable = 1; rtcAlarm = 1; step(1); rtcAlarm = 0; rtcEnable = 0;
    chk("R3", "rtc wake", asleep, 0);
    chk("R3", "rtc wakeSrc", wakeSrc, 5'b00100);
    step(RST);
    padRelease = 1; step(1); padRelease = 0;
  endtask

  task automatic t_int();
    intEnable = 1; intPolarity = 1; intPin = 1; step(3);
    enterSleep();
    step(6);
    chk("R5", "level at entry no wake", asleep, 1);
    intPin = 0; step(5);
    chk("R5", "leaving level no wake", asleep, 1);
    intPin = 1; step(2);
    chk("R5", "sync latency", asleep, 1);
    step(1);
    chk("R5", "edge wake", asleep, 0);
    chk("R3", "int wakeSrc", wakeSrc, 5'b10000);
    step(RST);
    // disabled at entry
    intEnable = 0; intPin = 0; step(3);
    enterSleep();
    intPin = 1; step(5);
    chk("R5", "disabled no wake", asleep, 1);
    porEvent = 1; step(1); porEvent = 0;
    chk("R3", "por wakeSrc", wakeSrc, 5'b00001);
    step(RST);
    // low polarity
    intEnable = 1; intPolarity = 0; step(1);
    enterSleep();
    intPin = 0; step(3);
    chk("R5", "low polarity wake", wakeSrc, 5'b10000);
    intEnable = 0;
    step(RST);
    padRelease = 1; step(1); padRelease = 0;
  endtask

  task automatic t_brown();
    brownOut = 1; step(1); brownOut = 0;
    chk("R8", "brownout awake ignored", brownOutFlag, 0);
    enterSleep();
    brownOut = 1; step(1); brownOut = 0;
    chk("R8", "brownout set", brownOutFlag, 1);
    wdtTimeout = 1; step(1); wdtTimeout = 0;
    step(RST);
    chk("R8", "brownout sticky", brownOutFlag, 1);
    clrBrownOut = 1; step(1); clrBrownOut = 0;
    chk("R8", "brownout cleared", brownOutFlag, 0);
    padRelease = 1; step(1); padRelease = 0;
  endtask

  task automatic t_gpr();
    gprWe = 1; gprSel = 0; gprWdata = 16'hA5A5; step(1);
    gprSel = 1; gprWdata = 16'h3C3C; step(1); gprWe = 0;
    chk("R9", "gpr0 write", gprRd0, 16'hA5A5);
    chk("R9", "gpr1 write", gprRd1, 16'h3C3C);
    enterSleep();
    gprWe = 1; gprSel = 0; gprWdata = 16'hFFFF; step(1); gprWe = 0;
    chk("R9", "write asleep ignored", gprRd0, 16'hA5A5);
    porEvent = 1; step(1); porEvent = 0;
    gprWe = 1; gprSel = 1; gprWdata = 16'h0000; step(1); gprWe = 0;
    step(RST);
    chk("R9", "gpr0 retained", gprRd0, 16'hA5A5);
    chk("R9", "gpr1 retained", gprRd1, 16'h3C3C);
    padRelease = 1; step(1); padRelease = 0;
  endtask

  task automatic t_pads();
    padOe = 4'b0011; padOut = 4'b0101; step(1);
    chk("R10", "live oe", padOeOut, 4'b0011);
    chk("R10", "live drive", padDrive, 4'b0001);
    enterSleep();
    padOe = 4'b1111; padOut = 4'b1111; step(1);
    chk("R10", "frozen oe", padOeOut, 4'b0011);
    chk("R10", "frozen drive", padDrive, 4'b0001);
    padRelease = 1; step(1); padRelease = 0;
    chk("R10", "release asleep ignored", padsFrozen, 1);
    extRstN = 0; step(1); extRstN = 1;
    chk("R3", "ext reset wakeSrc", wakeSrc, 5'b01000);
    step(RST + 2);
    chk("R10", "frozen after wake", padOeOut, 4'b0011);
    padRelease = 1; step(1); padRelease = 0;
    chk("R10", "released oe", padOeOut, 4'b1111);
    chk("R10", "released drive", padDrive, 4'b1111);
  endtask

  task automatic t_req_window();
    enterSleep();
    wdtTimeout = 1; step(1); wdtTimeout = 0;
    sleepReq = 1; step(1); sleepReq = 0;
    step(RST);
    chk("R11", "request in window ignored", asleep, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rstN = 1;
    step(1);
    t_reset();
    t_wdt_window();
    t_rtc();
    t_int();
    t_brown();
    t_gpr();
    t_pads();
    t_req_window();
    step(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule